// File: doc/BRIEF.md
# Serial ADC Front-End Mode Controller

This block is the digital serial slave of a two-channel, 10-bit sampling converter. A host frames each transfer by pulling `frame_n` low and toggling `bit_clk`. The block counts the falling edges of `bit_clk` inside the frame. It samples a control word from `ctl_in` most significant bit first, and shifts a result word out on `data_out`. The converter core is not modelled. A 10-bit input, `sample_in`, supplies the value that is captured when a frame opens.

The operating mode has no register. The host picks the next mode by the number of falling edges already counted when it raises `frame_n`. The three modes are normal conversion, cascade (daisy-chain) and power-down. In cascade mode the output register works as a plain shift register, so several instances can be chained. Two other state outputs are modelled: a flag that the core is powered, and a track/hold control. The reset mode is a parameter, so the undefined power-on mode can be tested.

All pins are sampled on the system clock `clk`. They are assumed to be synchronised upstream, and each level must last at least one `clk` cycle.

Top module: `adc_serial_mode_ctrl`

## Requirements
- R1: After reset, `mode` equals the RESET_MODE parameter, and `powered`, `chain_valid` and `track` are all 0. The mode encoding is 0 for normal, 1 for cascade and 2 for power-down.
- R2: `data_oe` is 1 exactly in the cycles after a cycle in which `frame_n` was sampled low. Raising `frame_n` early therefore releases the output on the next cycle.
- R3: A frame closed after 2 to 9 falling edges selects power-down, from any mode. It also clears `powered` and `track`.
- R4: From normal or power-down mode, a frame closed after 10 or 11 edges selects cascade with `chain_valid` = 1. A frame closed after exactly 12 edges selects cascade with `chain_valid` = 0. `chain_valid` is 0 whenever the mode is not cascade.
- R5: From normal or power-down mode, a frame closed after 13 or more edges selects normal mode. Any frame of 10 or more edges that ends outside power-down sets `powered`.
- R6: From cascade mode, a frame closed after 10 to 12 edges returns to normal mode.
- R7: From cascade mode, a frame closed after 13 or more edges stays in cascade when the channel bit differs from the keep bit. It returns to normal when the two bits are equal. The channel bit is the `ctl_in` value at falling edge 3 (control word bit 13). The keep bit is the value at edge 4 (bit 12).
- R8: A frame closed after 0 or 1 edges leaves `mode`, `powered` and `chain_valid` unchanged. None of the three changes while `frame_n` is low.
- R9: `track` goes to 0 in the cycle after `frame_n` falls. It goes to 1 on the 5th falling edge of the frame.
- R10: When a frame opens, the output word is loaded as {0, channel bit of the last frame that reached edge 3 (0 after reset), `sample_in`[9:0], 4'b0000}. `data_out` shows bit 15 of the word. Each falling edge shifts the word left by one bit. In cascade mode the `ctl_in` bit enters the bottom; in the other modes a 0 enters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Frame select, active low |
| bit_clk | input | 1 | Serial bit clock; falling edges are counted |
| ctl_in | input | 1 | Serial control / cascade data input |
| sample_in | input | 10 | Converted value from the core |
| data_out | output | 1 | Serial output bit |
| data_oe | output | 1 | Output enable (0 = three-state) |
| track | output | 1 | Track/hold control, 1 = track |
| mode | output | 2 | Current mode: 0 normal, 1 cascade, 2 power-down |
| powered | output | 1 | Core considered powered up |
| chain_valid | output | 1 | Cascade data will be valid |

## Verification
The bench closes frames at every edge count from 0 to 16. It aims at the window boundaries 1/2, 9/10, 11/12 and 12/13. A controller that is off by one edge would give power-down where cascade was expected, or would flag invalid cascade data as valid. Cascade frames are sent with equal and with unequal channel/keep bits. Shortened exits from cascade are also sent, so a design that ignores the current mode when decoding a close would be caught. The output stream is compared bit by bit, including the cascade bits that arrive from `ctl_in`. A second instance resets into power-down to cover the alternate power-on state.

// File: rtl/adc_mode_pkg.sv
package adc_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_DAISY  = 2'd1,
        MODE_PWRDN  = 2'd2
    } mode_e;

    // edge-count thresholds applied when the frame closes
    localparam int unsigned PD_MIN     = 2;
    localparam int unsigned CHAIN_MIN  = 10;
    localparam int unsigned CHAIN_BAD  = 12;
    localparam int unsigned CONV_MIN   = 13;
    // edge ordinals for captured bits and track release
    localparam int unsigned CHN_EDGE   = 3;
    localparam int unsigned KEEP_EDGE  = 4;
    localparam int unsigned TRACK_EDGE = 5;

    typedef struct packed {
        mode_e mode;
        logic  powered;
        logic  chain_ok;
    } mode_state_t;

    function automatic mode_state_t next_state(mode_state_t cur, int unsigned n,
                                               logic chn, logic keep);
        mode_state_t nx;
        nx = cur;
        if (n < PD_MIN) begin
            nx = cur;
        end else if (n < CHAIN_MIN) begin
            nx.mode = MODE_PWRDN;
        end else if (n <= CHAIN_BAD) begin
            nx.mode = (cur.mode == MODE_DAISY) ? MODE_NORMAL : MODE_DAISY;
        end else if (cur.mode == MODE_DAISY) begin
            nx.mode = (chn == keep) ? MODE_NORMAL : MODE_DAISY;
        end else begin
            nx.mode = MODE_NORMAL;
        end

        if (n >= PD_MIN) begin
            nx.powered = (nx.mode != MODE_PWRDN) && (n >= CHAIN_MIN);
            if (nx.mode != MODE_DAISY)
                nx.chain_ok = 1'b0;
            else if (cur.mode != MODE_DAISY)
                nx.chain_ok = (n < CHAIN_BAD);
            else
                nx.chain_ok = cur.chain_ok;
        end
        return nx;
    endfunction

endpackage

// File: rtl/adc_edge_counter.sv
module adc_edge_counter
    import adc_mode_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             bit_clk,
    input  logic             ctl_in,
    output logic             open_ev,
    output logic             close_ev,
    output logic             edge_ev,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output logic             chn,
    output logic             keep
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CHN_AT  = CNT_W'(CHN_EDGE - 1);
    localparam logic [CNT_W-1:0] KEEP_AT = CNT_W'(KEEP_EDGE - 1);

    logic frame_q;
    logic clk_q;

    assign active   = ~frame_q;
    assign open_ev  = frame_q & ~frame_n;
    assign close_ev = ~frame_q & frame_n;
    assign edge_ev  = clk_q & ~bit_clk & ~frame_q & ~frame_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b1;
            clk_q   <= 1'b1;
            cnt     <= '0;
            chn     <= 1'b0;
            keep    <= 1'b0;
        end else begin
            frame_q <= frame_n;
            clk_q   <= bit_clk;
            if (open_ev) begin
                cnt <= '0;
            end else if (edge_ev) begin
                if (cnt != CNT_MAX)
                    cnt <= cnt + 1'b1;
                if (cnt == CHN_AT)
                    chn <= ctl_in;
                if (cnt == KEEP_AT)
                    keep <= ctl_in;
            end
        end
    end

endmodule

// File: rtl/adc_mode_fsm.sv
module adc_mode_fsm
    import adc_mode_pkg::*;
#(
    parameter int unsigned CNT_W      = 5,
    parameter mode_e       RESET_MODE = MODE_NORMAL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_ev,
    input  logic             close_ev,
    input  logic             edge_ev,
    input  logic [CNT_W-1:0] cnt,
    input  logic             chn,
    input  logic             keep,
    output mode_state_t      st,
    output logic             track
);
    localparam logic [CNT_W-1:0] TRACK_AT = CNT_W'(TRACK_EDGE - 1);

    mode_state_t st_nx;

    always_comb begin
        st_nx = next_state(st, 32'(cnt), chn, keep);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.mode     <= RESET_MODE;
            st.powered  <= 1'b0;
            st.chain_ok <= 1'b0;
            track       <= 1'b0;
        end else begin
            if (close_ev)
                st <= st_nx;
            if (open_ev)
                track <= 1'b0;
            else if (edge_ev && cnt == TRACK_AT)
                track <= 1'b1;
            else if (close_ev && st_nx.mode == MODE_PWRDN && 32'(cnt) >= PD_MIN)
                track <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_out_shifter.sv
module adc_out_shifter #(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  shift,
    input  logic                  fill,
    input  logic [FRAME_BITS-1:0] word,
    output logic                  msb
);
    logic [FRAME_BITS-1:0] sreg;

    assign msb = sreg[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst)
            sreg <= '0;
        else if (load)
            sreg <= word;
        else if (shift)
            sreg <= {sreg[FRAME_BITS-2:0], fill};
    end

endmodule

// File: rtl/adc_serial_mode_ctrl.sv
module adc_serial_mode_ctrl
    import adc_mode_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned RES_BITS   = 10,
    parameter mode_e       RESET_MODE = MODE_NORMAL
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_n,
    input  logic                bit_clk,
    input  logic                ctl_in,
    input  logic [RES_BITS-1:0] sample_in,
    output logic                data_out,
    output logic                data_oe,
    output logic                track,
    output logic [1:0]          mode,
    output logic                powered,
    output logic                chain_valid
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
    localparam int unsigned PAD_W = FRAME_BITS - RES_BITS - 2;

    logic             open_ev, close_ev, edge_ev, active;
    logic [CNT_W-1:0] cnt;
    logic             chn, keep;
    mode_state_t      st;
    logic [FRAME_BITS-1:0] word;

    adc_edge_counter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .frame_n(frame_n), .bit_clk(bit_clk), .ctl_in(ctl_in),
        .open_ev(open_ev), .close_ev(close_ev), .edge_ev(edge_ev), .active(active),
        .cnt(cnt), .chn(chn), .keep(keep)
    );

    adc_mode_fsm #(.CNT_W(CNT_W), .RESET_MODE(RESET_MODE)) u_fsm (
        .clk(clk), .rst(rst), .open_ev(open_ev), .close_ev(close_ev), .edge_ev(edge_ev),
        .cnt(cnt), .chn(chn), .keep(keep), .st(st), .track(track)
    );

    assign word = {1'b0, chn, sample_in, {PAD_W{1'b0}}};

    adc_out_shifter #(.FRAME_BITS(FRAME_BITS)) u_out (
        .clk(clk), .rst(rst), .load(open_ev), .shift(edge_ev),
        .fill((st.mode == MODE_DAISY) ? ctl_in : 1'b0),
        .word(word), .msb(data_out)
    );

    assign data_oe     = active;
    assign mode        = st.mode;
    assign powered     = st.powered;
    assign chain_valid = st.chain_ok;

endmodule

// File: rtl/adc_mode_checker.sv
module adc_mode_checker (
    input logic       clk,
    input logic       rst,
    input logic       frame_n,
    input logic       data_oe,
    input logic       track,
    input logic [1:0] mode,
    input logic       powered,
    input logic       chain_valid
);
    AST_OE_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (data_oe == !$past(frame_n))); // R2
    AST_PWRDN_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2) |-> !powered); // R3
    AST_VALID_IN_CHAIN: assert property (@(posedge clk) disable iff (rst)
        chain_valid |-> (mode == 2'd1)); // R4
    AST_HOLD_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_n) |=> !track); // R9
    AST_MODE_STABLE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> ($stable(mode) && $stable(powered) && $stable(chain_valid))); // R8
endmodule

bind adc_serial_mode_ctrl adc_mode_checker u_chk (
    .clk(clk), .rst(rst), .frame_n(frame_n), .data_oe(data_oe), .track(track),
    .mode(mode), .powered(powered), .chain_valid(chain_valid)
);

// File: tb/tb_adc_serial_mode_ctrl.sv
module tb_adc_serial_mode_ctrl;
    import adc_mode_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_n = 1'b1;
    logic bit_clk = 1'b1;
    logic ctl_in = 1'b0;
    logic [9:0] sample_in = '0;
    logic data_out, data_oe, track, powered, chain_valid;
    logic [1:0] mode;
    logic pd_out, pd_oe, pd_track, pd_pw, pd_cv;
    logic [1:0] pd_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_mode = 0;
    bit exp_pw = 0;
    bit exp_cv = 0;
    bit exp_ch = 0;

    always #5 clk = ~clk;

    adc_serial_mode_ctrl dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .bit_clk(bit_clk), .ctl_in(ctl_in),
        .sample_in(sample_in), .data_out(data_out), .data_oe(data_oe), .track(track),
        .mode(mode), .powered(powered), .chain_valid(chain_valid)
    );

    adc_serial_mode_ctrl #(.RESET_MODE(MODE_PWRDN)) dut_pd (
        .clk(clk), .rst(rst), .frame_n(frame_n), .bit_clk(bit_clk), .ctl_in(ctl_in),
        .sample_in(sample_in), .data_out(pd_out), .data_oe(pd_oe), .track(pd_track),
        .mode(pd_mode), .powered(pd_pw), .chain_valid(pd_cv)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // expected next mode from the requirements (0 normal, 1 cascade, 2 power-down)
    function automatic int exp_next(int cur, int n, bit c, bit k);
        if (n < 2) return cur;
        if (n <= 9) return 2;
        if (n <= 12) return (cur == 1) ? 0 : 1;
        if (cur == 1) return (c == k) ? 0 : 1;
        return 0;
    endfunction

    task automatic run_frame(int n, logic [15:0] w, logic [9:0] s);
        logic [15:0] sr;
        int nm;
        bit fill;
        sr = {1'b0, exp_ch, s, 4'b0000};
        sample_in = s;
        frame_n = 1'b0;
        tick();
        chk("R2 oe on open", int'(data_oe), 1);
        chk("R10 first bit", int'(data_out), int'(sr[15]));
        chk("R9 hold after open", int'(track), 0);
        tick();
        for (int k = 1; k <= n; k++) begin
            ctl_in = w[16-k];
            bit_clk = 1'b0;
            tick();
            fill = (exp_mode == 1) ? w[16-k] : 1'b0;
            sr = {sr[14:0], fill};
            chk("R10 shifted bit", int'(data_out), int'(sr[15]));
            chk("R9 track vs edge", int'(track), (k >= 5) ? 1 : 0);
            bit_clk = 1'b1;
            tick();
        end
        frame_n = 1'b1;
        tick();
        chk("R2 oe released", int'(data_oe), 0);
        tick();
        nm = exp_next(exp_mode, n, w[13], w[12]);
        if (n >= 2) begin
            if (nm == 2) exp_pw = 0;
            else if (n >= 10) exp_pw = 1;
            else exp_pw = 0;
            if (nm != 1) exp_cv = 0;
            else if (exp_mode != 1) exp_cv = (n < 12);
        end
        exp_mode = nm;
        if (n >= 3) exp_ch = w[13];
        chk("R3 R4 R5 R6 R7 R8 mode", int'(mode), exp_mode);
        chk("R3 R5 R8 powered", int'(powered), int'(exp_pw));
        chk("R4 R8 chain_valid", int'(chain_valid), int'(exp_cv));
        if (n >= 2 && exp_mode == 2)
            chk("R3 hold in power-down", int'(track), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 mode", int'(mode), 0);
        chk("R1 powered", int'(powered), 0);
        chk("R1 chain_valid", int'(chain_valid), 0);
        chk("R1 track", int'(track), 0);
        chk("R1 alt reset mode", int'(pd_mode), 2);
        chk("R2 idle oe", int'(data_oe), 0);

        run_frame(14, 16'h1234, 10'h2A5);   // R5 dummy frame to normal
        chk("R5 alt instance leaves power-down", int'(pd_mode), 0);
        chk("R5 alt instance powered", int'(pd_pw), 1);
        run_frame(10, 16'hFFFF, 10'h3FF);   // R4 valid cascade
        run_frame(16, 16'hA5C3, 10'h155);   // R7 bits 13/12 = 1/0 stay
        run_frame(16, 16'h3000, 10'h0AA);   // R7 equal bits leave
        run_frame(12, 16'h0F0F, 10'h001);   // R4 invalid cascade
        run_frame(11, 16'h8001, 10'h200);   // R6 dummy exit
        run_frame(1, 16'hFFFF, 10'h111);    // R8 short frame
        run_frame(0, 16'h0000, 10'h222);    // R8 empty frame
        run_frame(5, 16'h5555, 10'h333);    // R3 power-down
        run_frame(11, 16'h2AAA, 10'h0F0);   // R4 cascade from power-down
        run_frame(9, 16'h7777, 10'h1E1);    // R3 boundary
        run_frame(13, 16'h4000, 10'h0C3);   // R5 boundary from power-down
        run_frame(2, 16'h0000, 10'h3C3);    // R3 lower boundary
        run_frame(16, 16'hFFFF, 10'h2DB);   // R5 full frame

        for (int i = 0; i < 400; i++) begin
            int n;
            n = int'($urandom_range(16, 0));
            run_frame(n, 16'($urandom()), 10'($urandom()));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule